// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Break Input

This block gathers thirty-one maskable request lines from on-chip peripherals and one active-low emergency break pin. Every maskable line carries its own 3-bit urgency level, written through a simple write-only register port. Level 0 is the most urgent; level 7 switches the line off. On every cycle the block picks the most urgent pending line, breaking ties by taking the lowest line index. It presents that line's index and level. It raises one interrupt request towards the processor when the winner is strictly more urgent than a programmable current-level threshold.

The break pin is brought into the clock domain through two flip-flops. A high-to-low transition then latches a separate break request. The current-level threshold has no effect on it, and neither does any enable outside the block. The request stays up until software writes a clear strobe. A pin that stays low does not raise it again.

Top module: `prio_intc`

## Requirements
- R1: After reset every line level is 7 (off), the threshold is 7, the break request is 0, `irq_o` is 0, and the outputs show index 31 with level 7.
- R2: `src_req_i` is captured on each rising clock edge, and the winner outputs reflect the captured value from that edge on.
- R3: A line whose level is 7 never wins, even while it requests.
- R4: Among captured requests from enabled lines, the one with the numerically smallest level wins.
- R5: When several requesting lines share the smallest level, the lowest index wins.
- R6: `irq_o` is 1 exactly when a winner exists and its level is numerically below the threshold. With no winner the outputs show index 31 and level 7.
- R7: A write with `cfg_addr_i` 0..30 sets that line's level to `cfg_data_i`. Address 32 sets the threshold. Address 33 with `cfg_data_i[0]`=1 clears the break request. Writes to any other address change nothing.
- R8: When `brk_ni` goes low before edge k, `brk_irq_o` is 1 from edge k+2 on, whatever the threshold.
- R9: A cleared break request stays 0 while the pin stays low, and a rising pin never sets it.
- R10: If a falling edge and a clear strobe reach the break request on the same edge, the request ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| src_req_i | input | 31 | Level request lines from peripherals, bit n is line n |
| brk_ni | input | 1 | Asynchronous active-low break pin |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 6 | Register write address |
| cfg_data_i | input | 3 | Register write data |
| irq_o | output | 1 | Maskable interrupt request to the processor |
| win_idx_o | output | 5 | Index of the winning line, 31 when none |
| win_lvl_o | output | 3 | Level of the winning line, 7 when none |
| brk_irq_o | output | 1 | Latched non-maskable break request |

## Verification
Two events can land on one edge: a detected break edge and the clear strobe. The bench provokes this by writing address 33 during the cycle right after the second synchronizer stage has gone low. The break request must read 1 afterwards. A level write to a line can also coincide with a change of that line's request. Long runs of random writes, requests and pin toggles provoke this, and a behavioural model compares all four outputs on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  // all-ones level switches a line off
  localparam lvl_t LVL_OFF = '1;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  lvl_t              data_i,
  output lvl_t              lvl_o [NUM_SRC],
  output lvl_t              thr_o,
  output logic              brk_clr_o
);
  localparam logic [ADDR_W-1:0] THR_ADDR = ADDR_W'(2**IDX_W);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(2**IDX_W + 1);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    logic sel;
    lvl_t lvl_d, lvl_q;
    assign sel = we_i && (addr_i == ADDR_W'(g));
    always_comb begin
      lvl_d = lvl_q;
      if (sel) lvl_d = data_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= LVL_OFF;
      else         lvl_q <= lvl_d;
    end
    assign lvl_o[g] = lvl_q;
  end

  logic thr_en;
  lvl_t thr_d, thr_q;
  assign thr_en = we_i && (addr_i == THR_ADDR);
  always_comb begin
    thr_d = thr_q;
    if (thr_en) thr_d = data_i;
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= LVL_OFF;
    else         thr_q <= thr_d;
  end
  assign thr_o     = thr_q;
  assign brk_clr_o = we_i && (addr_i == CLR_ADDR) && data_i[0];
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  lvl_t               lvl_i [NUM_SRC],
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o,
  output lvl_t               lvl_o
);
  always_comb begin
    lvl_o = LVL_OFF;
    idx_o = IDX_W'(NUM_SRC);
    // strict compare keeps the earlier (lower) index on equal levels
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (lvl_i[i] < lvl_o)) begin
        lvl_o = lvl_i[i];
        idx_o = IDX_W'(i);
      end
    end
    vld_o = (lvl_o != LVL_OFF);
  end
endmodule

// File: rtl/intc_brk_det.sv
module intc_brk_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic clr_i,
  output logic fall_o,
  output logic pend_o
);
  logic s1_q, s2_q, old_q, pend_q, pend_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      old_q <= 1'b1;
    end else begin
      s1_q  <= pin_ni;
      s2_q  <= s1_q;
      old_q <= s2_q;
    end
  end

  assign fall_o = old_q && !s2_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i)  pend_d = 1'b0;
    if (fall_o) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end
  assign pend_o = pend_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter  int unsigned NUM_SRC = 31,
  localparam int unsigned IDX_W   = $clog2(NUM_SRC + 1),
  localparam int unsigned ADDR_W  = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               brk_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [LVL_W-1:0]   cfg_data_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [LVL_W-1:0]   win_lvl_o,
  output logic               brk_irq_o
);
  logic [NUM_SRC-1:0] req_q;
  lvl_t               lvl [NUM_SRC];
  lvl_t               thr;
  logic               brk_clr, brk_fall, win_vld;
  lvl_t               win_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= src_req_i;
  end

  intc_cfg_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .data_i(cfg_data_i), .lvl_o(lvl), .thr_o(thr), .brk_clr_o(brk_clr));

  intc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req_i(req_q), .lvl_i(lvl), .vld_o(win_vld), .idx_o(win_idx_o), .lvl_o(win_lvl));

  intc_brk_det u_brk (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(brk_ni), .clr_i(brk_clr),
    .fall_o(brk_fall), .pend_o(brk_irq_o));

  assign win_lvl_o = win_lvl;
  assign irq_o     = win_vld && (win_lvl < thr);
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned IDX_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_q,
  input lvl_t               lvl [NUM_SRC],
  input lvl_t               thr,
  input logic               brk_clr,
  input logic               brk_fall,
  input logic               win_vld,
  input logic               irq_o,
  input logic [IDX_W-1:0]   win_idx_o,
  input logic [LVL_W-1:0]   win_lvl_o,
  input logic               brk_irq_o
);
  // R6
  irq_below_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_lvl_o < thr));
  // R6
  idle_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_vld |-> (win_idx_o == IDX_W'(NUM_SRC)) && (win_lvl_o == LVL_OFF) && !irq_o);
  // R3
  winner_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld |-> req_q[win_idx_o] && (lvl[win_idx_o] == win_lvl_o) && (win_lvl_o != LVL_OFF));
  // R8
  brk_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_irq_o) |-> $past(brk_fall));
  // R9
  brk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_irq_o && !brk_clr) |=> brk_irq_o);
  // R9
  brk_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_clr && !brk_fall) |=> !brk_irq_o);
  // R10
  brk_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_fall |=> brk_irq_o);
endmodule

bind prio_intc intc_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_q(req_q), .lvl(lvl), .thr(thr),
  .brk_clr(brk_clr), .brk_fall(brk_fall), .win_vld(win_vld), .irq_o(irq_o),
  .win_idx_o(win_idx_o), .win_lvl_o(win_lvl_o), .brk_irq_o(brk_irq_o));

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  localparam int NS = 31;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          brk_n;
  logic          we;
  logic [5:0]    addr;
  logic [2:0]    data;
  logic          irq, brk_irq;
  logic [4:0]    widx;
  logic [2:0]    wlvl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  prio_intc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src), .brk_ni(brk_n),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_data_i(data),
    .irq_o(irq), .win_idx_o(widx), .win_lvl_o(wlvl), .brk_irq_o(brk_irq));

  // behavioural reference model
  int m_lvl[NS];
  int m_thr, m_brk;
  bit m_req[NS];
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lvl[i]) begin m_lvl[i] = 7; m_req[i] = 0; end
      m_thr = 7; m_brk = 0;
      hist = '{1'b1, 1'b1, 1'b1, 1'b1};
    end else begin
      bit fall, clr;
      hist.push_front(brk_n);
      void'(hist.pop_back());
      fall = (hist[2] == 1'b0) && (hist[3] == 1'b1);
      clr  = we && (addr == 6'd33) && data[0];
      if (fall) m_brk = 1; else if (clr) m_brk = 0;
      if (we && addr < 6'd31) m_lvl[addr] = data;
      if (we && addr == 6'd32) m_thr = data;
      for (int i = 0; i < NS; i++) m_req[i] = src[i];
    end
  end

  task automatic chk(string t, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int e_idx = 31, e_lvl = 7;
    bit found = 0;
    for (int l = 0; l < 7 && !found; l++)
      for (int i = 0; i < NS && !found; i++)
        if (m_req[i] && m_lvl[i] == l) begin found = 1; e_idx = i; e_lvl = l; end
    chk(tag, int'(widx), e_idx, "win_idx");
    chk(tag, int'(wlvl), e_lvl, "win_lvl");
    chk(tag, int'(irq), int'(found && e_lvl < m_thr), "irq");
    chk(tag, int'(brk_irq), m_brk, "brk_irq");
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(int a, int d);
    we = 1; addr = 6'(a); data = 3'(d);
    step();
    we = 0;
  endtask

  task automatic expect_out(string t, int e_irq, int e_idx, int e_lvl, int e_brk);
    chk(t, int'(irq), e_irq, "irq direct");
    chk(t, int'(widx), e_idx, "win_idx direct");
    chk(t, int'(wlvl), e_lvl, "win_lvl direct");
    chk(t, int'(brk_irq), e_brk, "brk_irq direct");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src = '0; brk_n = 1; we = 0; addr = '0; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; step();
    expect_out("R1", 0, 31, 7, 0);

    tag = "R2"; wr(3, 4); src = NS'(1) << 3; step();
    expect_out("R2", 1, 3, 4, 0);

    tag = "R5"; wr(10, 2); wr(20, 2);
    src = (NS'(1) << 3) | (NS'(1) << 10) | (NS'(1) << 20); step();
    expect_out("R5", 1, 10, 2, 0);

    tag = "R4"; wr(20, 1); step();
    expect_out("R4", 1, 20, 1, 0);

    tag = "R3"; src = NS'(1) << 5; step();
    expect_out("R3", 0, 31, 7, 0);
    wr(20, 7); src = NS'(1) << 20; step();
    expect_out("R3", 0, 31, 7, 0);

    tag = "R6"; src = NS'(1) << 10; wr(32, 2); step();
    expect_out("R6", 0, 10, 2, 0);
    wr(32, 3); step();
    expect_out("R6", 1, 10, 2, 0);

    tag = "R7"; wr(31, 0); wr(40, 0); wr(34, 1); wr(63, 0); step();
    expect_out("R7", 1, 10, 2, 0);

    tag = "R8"; wr(32, 0); brk_n = 0;
    step(); step();
    expect_out("R8", 0, 10, 2, 0);
    step();
    expect_out("R8", 0, 10, 2, 1);

    tag = "R9"; wr(33, 1);
    expect_out("R9", 0, 10, 2, 0);
    repeat (5) step();
    expect_out("R9", 0, 10, 2, 0);
    brk_n = 1; repeat (4) step();
    expect_out("R9", 0, 10, 2, 0);

    tag = "R10"; brk_n = 0; step(); step();
    wr(33, 1);
    expect_out("R10", 0, 10, 2, 1);
    wr(33, 1); brk_n = 1;
    expect_out("R10", 0, 10, 2, 0);

    tag = "R2";
    for (int c = 0; c < 600; c++) begin
      src = NS'($urandom);
      if (($urandom % 4) == 0) begin
        we = 1; addr = 6'($urandom % 36); data = 3'($urandom);
      end else begin
        we = 0;
      end
      if (($urandom % 9) == 0) brk_n = ~brk_n;
      step();
    end
    we = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule